// File: doc/BRIEF.md
# Selectable Falling-Edge Timer Tick Generator

This block produces the timer tick that drives a timer counter in a larger design. A 14-bit system counter advances once per machine cycle. Its upper eight bits are visible as a read-only divider value, and a write to the divider clears the whole counter. A 3-bit control field holds an enable bit and a 2-bit clock select. The clock select picks one counter bit. That bit is ANDed with the enable, and the result goes to a falling-edge detector that emits a single-cycle tick.

Because the tick is taken from a falling edge of the gated bit, the block also ticks at times other than the plain counting period. A tick follows whenever the gated level drops from 1 to 0. This happens when the counter is cleared while the selected bit is 1. It happens when the select moves from a bit that is 1 to a bit that is 0. It also happens when the enable is cleared while the selected bit is 1. Downstream logic relies on these extra ticks, so the block reproduces them exactly. A stop input freezes the counter.

Top module: `tick_edge_timer`

## Requirements
- R1: After reset, tick_o is 0, div_rdata_o is 0x00 and ctl_rdata_o is 0xF8.
- R2: The system counter increases by one on every clock edge where stop_i and div_wr_i are low, and div_rdata_o always shows counter bits 13 to 6.
- R3: While stop_i is high, the counter holds its value and no tick is caused by counting.
- R4: A div_wr_i pulse sets the whole counter to zero on that edge, whatever the stop input; counting then restarts from zero.
- R5: Control bit 2 is the enable and bits 1..0 are the clock select; select 00, 01, 10 and 11 take counter bits 7, 1, 3 and 5. With select k mapped to bit b and enabled, ticks fall every 2^(b+1) cycles counted from a clear. With the enable at 0 there are no ticks.
- R6: A tick is high for exactly one cycle. It is high in the cycle right after the edge on which the gated level fell.
- R7: A divider write while enabled and with the selected bit at 1 produces a tick. The same write with the selected bit at 0 produces none.
- R8: A control write that moves the selection from a bit at 1 to a bit at 0 produces a tick. With the counter at 0x3FF0 and control at 0xFC, writing 0x05 or 0x06 ticks, and writing 0x04 or 0x07 does not.
- R9: Clearing the enable while the selected bit is 1 gives exactly one tick and then none. Clearing it while the bit is 0 gives no tick.
- R10: Control readback bits 7..3 always read 1. Only bits 2..0 are stored from ctl_wdata_i on a ctl_wr_i edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Freezes the system counter while high |
| div_wr_i | input | 1 | Divider write strobe, clears the counter |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| tick_o | output | 1 | One-cycle timer tick pulse |
| div_rdata_o | output | 8 | Divider readback, counter bits 13..6 |
| ctl_rdata_o | output | 8 | Control readback |

## Verification
Every result of this block falls due in the cycle right after the clock edge that applied its stimulus. The counter, control and edge registers take one edge. The tick and both readbacks are then formed combinationally from those registers. The bench drives inputs at the falling clock edge and lets one rising edge pass. It samples at the next falling edge, so each tick is observed in the one cycle it is allowed to occupy. The tick count over a window is computed as the window length divided by 2^(b+1), with the position of the first tick checked separately.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Counter bit driven by each clock-select code: 0 -> 7, n -> 2n-1.
  function automatic int src_bit(int sel);
    return (sel == 0) ? 7 : (2 * sel - 1);
  endfunction

endpackage

// File: rtl/tick_sys_counter.sv
module tick_sys_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Clear takes priority over the stop hold.
  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run_en)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_src_select.sv
module tick_src_select
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SEL_W = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic             gated_o
);

  localparam int NSRC = 2 ** SEL_W;

  logic [NSRC-1:0] cand;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    localparam int BIT_IDX = src_bit(gi);
    assign cand[gi] = cnt_i[BIT_IDX];
  end

  assign gated_o = cand[sel_i] & en_i;

endmodule

// File: rtl/tick_fall_detect.sv
module tick_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);

  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prev_q <= 1'b0;
    else
      prev_q <= prev_d;
  end

  assign pulse_o = prev_q & ~level_i;

endmodule

// File: rtl/tick_edge_timer.sv
module tick_edge_timer #(
  parameter int CNT_W = 14,
  parameter int DIV_W = 8,
  parameter int SEL_W = 2,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             div_wr_i,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_rdata_o,
  output logic [REG_W-1:0] ctl_rdata_o
);

  localparam int CTL_W   = SEL_W + 1;
  localparam int DIV_LSB = CNT_W - DIV_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // Control register: enable on top, select below.
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr_i)
      ctl_d = ctl_wdata_i[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      ctl_q <= '0;
    else
      ctl_q <= ctl_d;
  end

  logic [CNT_W-1:0] cnt;
  logic             gated;

  tick_sys_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_en (~stop_i),
    .clr    (div_wr_i),
    .cnt_o  (cnt)
  );

  tick_src_select #(
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
  ) u_sel (
    .cnt_i   (cnt),
    .sel_i   (ctl_q[SEL_W-1:0]),
    .en_i    (ctl_q[SEL_W]),
    .gated_o (gated)
  );

  tick_fall_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (gated),
    .pulse_o (tick_o)
  );

  assign div_rdata_o = cnt[CNT_W-1:DIV_LSB];
  assign ctl_rdata_o = {{(REG_W-CTL_W){1'b1}}, ctl_q};

endmodule

// File: rtl/tick_edge_timer_chk.sv
module tick_edge_timer_chk #(
  parameter int DIV_W = 8,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             div_wr_i,
  input logic             ctl_wr_i,
  input logic [REG_W-1:0] ctl_wdata_i,
  input logic             tick_o,
  input logic [DIV_W-1:0] div_rdata_o,
  input logic [REG_W-1:0] ctl_rdata_o
);

  p_div_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_i |=> (div_rdata_o == '0));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !div_wr_i) |=> $stable(div_rdata_o));

  p_tick_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  p_no_tick_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[2] |=> !tick_o);

  p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> (ctl_rdata_o[2:0] == $past(ctl_wdata_i[2:0])));

  p_ctl_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata_o[7:3] == 5'h1F);

endmodule

bind tick_edge_timer tick_edge_timer_chk #(
  .DIV_W (DIV_W),
  .REG_W (REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .div_wr_i    (div_wr_i),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_wdata_i (ctl_wdata_i),
  .tick_o      (tick_o),
  .div_rdata_o (div_rdata_o),
  .ctl_rdata_o (ctl_rdata_o)
);

// File: tb/sim_tick_edge_timer.sv
`timescale 1ns/1ps
module sim_tick_edge_timer;

  logic       clk;
  logic       rst_n;
  logic       stop_i;
  logic       div_wr_i;
  logic       ctl_wr_i;
  logic [7:0] ctl_wdata_i;
  logic       tick_o;
  logic [7:0] div_rdata_o;
  logic [7:0] ctl_rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tick_edge_timer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .div_wr_i    (div_wr_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .tick_o      (tick_o),
    .div_rdata_o (div_rdata_o),
    .ctl_rdata_o (ctl_rdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: control value, cycles to run, expected ticks, first tick cycle, expected divider.
  localparam logic [55:0] VEC [6] = '{
    {8'h04, 16'd600, 8'd2, 16'd256, 8'd9},
    {8'h05, 16'd20,  8'd5, 16'd4,   8'd0},
    {8'h06, 16'd40,  8'd2, 16'd16,  8'd0},
    {8'h07, 16'd200, 8'd3, 16'd64,  8'd3},
    {8'h01, 16'd40,  8'd0, 16'd0,   8'd0},
    {8'hFD, 16'd12,  8'd3, 16'd4,   8'd0}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Leaves the counter at zero, control at v, and no pending edge.
  task automatic clear_with(logic [7:0] v);
    ctl_wr_i = 1'b1; ctl_wdata_i = 8'h00;
    step();
    div_wr_i = 1'b1; ctl_wdata_i = v;
    step();
    div_wr_i = 1'b0; ctl_wr_i = 1'b0;
  endtask

  task automatic ctl_write(logic [7:0] v);
    ctl_wr_i = 1'b1; ctl_wdata_i = v;
    step();
    ctl_wr_i = 1'b0;
  endtask

  task automatic sel_switch(logic [7:0] v, int exp);
    clear_with(8'hFC);
    repeat (16'h3FF0) step();
    ctl_write(v);
    chk("R8 select switch tick", int'(tick_o), exp);
    chk("R2 divider at 0x3FF1", int'(div_rdata_o), 8'hFF);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stop_i = 1'b0; div_wr_i = 1'b0;
    ctl_wr_i = 1'b0; ctl_wdata_i = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 tick after reset", int'(tick_o), 0);
    chk("R1 divider after reset", int'(div_rdata_o), 0);
    chk("R1 control after reset", int'(ctl_rdata_o), 8'hF8);

    // R5 / R2 / R4 / R6 table walk
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      int cyc, exp_t, exp_first, exp_div, got, first;
      v         = VEC[i][55:48];
      cyc       = int'(VEC[i][47:32]);
      exp_t     = int'(VEC[i][31:24]);
      exp_first = int'(VEC[i][23:8]);
      exp_div   = int'(VEC[i][7:0]);
      clear_with(v);
      chk("R4 no tick right after clear", int'(tick_o), 0);
      got = 0; first = 0;
      for (int j = 1; j <= cyc; j++) begin
        step();
        if (tick_o) begin
          got++;
          if (first == 0) first = j;
        end
      end
      chk("R5 tick count for select", got, exp_t);
      chk("R6 first tick cycle", first, exp_first);
      chk("R2 divider after run", int'(div_rdata_o), exp_div);
    end

    // R3 stop holds the counter
    begin
      int got;
      clear_with(8'h05);
      repeat (70) step();
      stop_i = 1'b1;
      got = 0;
      for (int j = 0; j < 200; j++) begin
        step();
        if (tick_o) got++;
      end
      chk("R3 no ticks while stopped", got, 0);
      chk("R3 divider frozen", int'(div_rdata_o), 1);
      stop_i = 1'b0;
      repeat (58) step();
      chk("R3 counting resumes", int'(div_rdata_o), 2);
    end

    // R7 divider write with selected bit set / clear
    clear_with(8'h05);
    repeat (2) step();
    div_wr_i = 1'b1;
    step();
    div_wr_i = 1'b0;
    chk("R7 clear with bit set ticks", int'(tick_o), 1);
    chk("R4 divider cleared", int'(div_rdata_o), 0);
    step();
    chk("R6 tick lasts one cycle", int'(tick_o), 0);

    clear_with(8'h05);
    repeat (5) step();
    div_wr_i = 1'b1;
    step();
    div_wr_i = 1'b0;
    chk("R7 clear with bit clear no tick", int'(tick_o), 0);

    // R4 clear wins over stop
    clear_with(8'h00);
    repeat (70) step();
    stop_i = 1'b1; div_wr_i = 1'b1;
    step();
    stop_i = 1'b0; div_wr_i = 1'b0;
    chk("R4 clear during stop", int'(div_rdata_o), 0);

    // R8 select switch at 0x3FF0
    sel_switch(8'h05, 1);
    sel_switch(8'h06, 1);
    sel_switch(8'h04, 0);
    sel_switch(8'h07, 0);

    // R9 disabling
    begin
      int got;
      clear_with(8'h05);
      repeat (2) step();
      ctl_write(8'h01);
      chk("R9 disable with bit set ticks", int'(tick_o), 1);
      got = 0;
      for (int j = 0; j < 20; j++) begin
        step();
        if (tick_o) got++;
      end
      chk("R9 only one tick after disable", got, 0);
      chk("R10 readback after 0x01", int'(ctl_rdata_o), 8'hF9);
    end
    clear_with(8'h05);
    repeat (5) step();
    ctl_write(8'h01);
    chk("R9 disable with bit clear no tick", int'(tick_o), 0);

    // R10 control readback
    ctl_write(8'h02);
    chk("R10 readback 0x02", int'(ctl_rdata_o), 8'hFA);
    ctl_write(8'hFF);
    chk("R10 readback 0xFF", int'(ctl_rdata_o), 8'hFF);
    ctl_write(8'h30);
    chk("R10 readback 0x30", int'(ctl_rdata_o), 8'hF8);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule